// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the transfer engine of one channel of an ISA-style DMA controller. It holds an 8-bit page value and a 16-bit address offset, and joins the two into a 24-bit physical address. On each accepted transfer strobe it moves the offset forward by one unit and decrements a 16-bit remaining-count register. On the last transfer of a programmed run it raises a one-cycle terminal-count pulse. A build-time parameter chooses the channel kind. A byte channel counts and addresses single bytes inside a 64K window. A word channel counts and addresses 16-bit words inside a 128K window; it shifts the offset left by one and drops the lowest page bit.

The page value is never changed by an offset carry, so a run wraps inside its window rather than crossing into the next one. A write to the base offset or the base count also loads the working copy and arms the channel. When the recycle input is high at terminal count, the working offset and count are restored from their base copies and the channel stays armed. When it is low, the channel ignores strobes until one of them is written again. Register decode, arbitration and the data path belong to the surrounding controller.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the physical address is 0, the terminal-count output is 0, and transfer strobes are ignored until the base offset or the base count has been written.
- R2: On a byte channel (WORD_CHAN=0) physical address bits 23:16 equal the page value and bits 15:0 equal the working offset.
- R3: On a word channel (WORD_CHAN=1) physical bit 0 is 0, bits 16:1 equal the working offset, bits 23:17 equal page bits 7:1, and page bit 0 has no effect.
- R4: Each accepted transfer strobe advances the working offset by exactly one. That is one byte on a byte channel and one word (physical +2) on a word channel.
- R5: When the working offset passes 0xFFFF it wraps to 0x0000, and the page part of the physical address stays unchanged.
- R6: A loaded count value K produces terminal count on the (K+1)-th accepted transfer. K=0 gives it on the first transfer.
- R7: Terminal count is a single-cycle pulse, high in the cycle after the clock edge that accepted the last transfer.
- R8: With recycle low, strobes after terminal count leave the physical address unchanged until the base offset or base count is written, which re-arms the channel.
- R9: With recycle high, the transfer that reaches terminal count restores the working offset and working count from their base copies, and the channel keeps accepting strobes.
- R10: Writing the base offset also sets the working offset. Later transfers do not alter the base copy, so a recycle returns to the written value.
- R11: Lane select is 2'b11 on a word channel. On a byte channel it is 2'b01 for an even physical address and 2'b10 for an odd one.
- R12: A base offset or base count write in the same cycle as a transfer strobe takes priority, and that strobe is not counted.
- R13: A loaded count of 0xFFFF performs 65536 transfers before terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_wr | input | 1 | Load page value |
| page_din | input | 8 | Page value |
| base_wr | input | 1 | Load base and working offset, re-arm |
| base_din | input | 16 | Offset value |
| cnt_wr | input | 1 | Load base and working count, re-arm |
| cnt_din | input | 16 | Count value (transfers minus one) |
| xfer | input | 1 | Transfer acknowledge strobe |
| recycle | input | 1 | Restore from base copies at terminal count |
| phys_addr | output | 24 | Physical address |
| lane_sel | output | 2 | Byte lanes used by the current transfer |
| tc | output | 1 | Terminal-count pulse |

## Verification
A byte-channel instance and a word-channel instance receive the same stimulus. The paired result separates the two address mappings, and an odd page value shows whether page bit 0 leaks into the word mapping. Offsets just below 0xFFFF show that the page part never takes a carry. Short counts with recycle low and with recycle high separate stopping from restoring. Counts of 0 and 0xFFFF probe the two ends of the minus-one count encoding. A write that collides with a strobe exposes the load priority.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int PAGE_W_DEF = 8;
    localparam int OFS_W_DEF  = 16;

    typedef enum logic {
        CH_BYTE = 1'b0,
        CH_WORD = 1'b1
    } chan_kind_e;

    typedef struct packed {
        logic accept;
        logic last;
        logic reload;
    } step_ctl_t;

    function automatic logic [1:0] lane_of(input chan_kind_e kind, input logic low_bit);
        if (kind == CH_WORD)
            return 2'b11;
        return low_bit ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dma_base_cur.sv
module dma_base_cur #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [W-1:0] nxt,
    input  logic         reload,
    output logic [W-1:0] cur
);
    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (ld) begin
            base_q <= ld_val;
            cur_q  <= ld_val;
        end else if (reload) begin
            cur_q  <= base_q;
        end else if (adv) begin
            cur_q  <= nxt;
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/dma_term_ctl.sv
module dma_term_ctl
    import dma_eng_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xfer,
    input  logic      rearm,
    input  logic      cnt_zero,
    input  logic      recycle,
    output step_ctl_t ctl,
    output logic      armed,
    output logic      tc
);
    logic armed_q;
    logic tc_q;

    always_comb begin
        ctl.accept = xfer && armed_q && !rearm;
        ctl.last   = ctl.accept && cnt_zero;
        ctl.reload = ctl.last && recycle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            tc_q    <= 1'b0;
        end else begin
            tc_q <= ctl.last;
            if (rearm)
                armed_q <= 1'b1;
            else if (ctl.last && !recycle)
                armed_q <= 1'b0;
        end
    end

    assign armed = armed_q;
    assign tc    = tc_q;
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
    import dma_eng_pkg::*;
#(
    parameter bit WORD_CHAN = 1'b0,
    parameter int PAGE_W    = PAGE_W_DEF,
    parameter int OFS_W     = OFS_W_DEF,
    localparam int PHYS_W   = PAGE_W + OFS_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  ofs,
    output logic [PHYS_W-1:0] phys,
    output logic [1:0]        lane
);
    generate
        if (WORD_CHAN) begin : g_word
            logic unused_pg0;
            assign unused_pg0 = page[0];
            assign phys = {page[PAGE_W-1:1], ofs, 1'b0};
            assign lane = lane_of(CH_WORD, 1'b0);
        end else begin : g_byte
            assign phys = {page, ofs};
            assign lane = lane_of(CH_BYTE, ofs[0]);
        end
    endgenerate
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter bit WORD_CHAN = 1'b0,
    parameter int PAGE_W    = PAGE_W_DEF,
    parameter int OFS_W     = OFS_W_DEF,
    localparam int PHYS_W   = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              base_wr,
    input  logic [OFS_W-1:0]  base_din,
    input  logic              cnt_wr,
    input  logic [OFS_W-1:0]  cnt_din,
    input  logic              xfer,
    input  logic              recycle,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [1:0]        lane_sel,
    output logic              tc
);
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  cur_ofs;
    logic [OFS_W-1:0]  cur_cnt;
    logic              armed;
    step_ctl_t         ctl;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (page_wr)
            page_q <= page_din;
    end

    dma_term_ctl u_term (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .rearm    (base_wr || cnt_wr),
        .cnt_zero (cur_cnt == '0),
        .recycle  (recycle),
        .ctl      (ctl),
        .armed    (armed),
        .tc       (tc)
    );

    dma_base_cur #(.W(OFS_W)) u_ofs (
        .clk    (clk),
        .rst    (rst),
        .ld     (base_wr),
        .ld_val (base_din),
        .adv    (ctl.accept),
        .nxt    (cur_ofs + 1'b1),
        .reload (ctl.reload),
        .cur    (cur_ofs)
    );

    dma_base_cur #(.W(OFS_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ld     (cnt_wr),
        .ld_val (cnt_din),
        .adv    (ctl.accept),
        .nxt    (cur_cnt - 1'b1),
        .reload (ctl.reload),
        .cur    (cur_cnt)
    );

    dma_phys_map #(
        .WORD_CHAN (WORD_CHAN),
        .PAGE_W    (PAGE_W),
        .OFS_W     (OFS_W)
    ) u_map (
        .page (page_q),
        .ofs  (cur_ofs),
        .phys (phys_addr),
        .lane (lane_sel)
    );
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter bit WORD_CHAN = 1'b0,
    parameter int PAGE_W    = 8,
    parameter int OFS_W     = 16,
    localparam int PHYS_W   = PAGE_W + OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              page_wr,
    input logic              base_wr,
    input logic              cnt_wr,
    input logic              xfer,
    input logic              recycle,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [1:0]        lane_sel,
    input logic              tc,
    input logic [OFS_W-1:0]  cur_ofs,
    input logic [OFS_W-1:0]  cur_cnt,
    input logic              armed
);
    logic [OFS_W-1:0] ofs_seen;
    assign ofs_seen = WORD_CHAN ? phys_addr[OFS_W:1] : phys_addr[OFS_W-1:0];

    assert_word_align_R3: assert property (@(posedge clk) disable iff (rst)
        WORD_CHAN |-> (phys_addr[0] == 1'b0));

    assert_lane_R11: assert property (@(posedge clk) disable iff (rst)
        WORD_CHAN ? (lane_sel == 2'b11)
                  : ($onehot0(lane_sel) && lane_sel != 2'b00 && lane_sel[1] == phys_addr[0]));

    assert_page_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(page_wr) |-> (phys_addr[PHYS_W-1:OFS_W+1] == $past(phys_addr[PHYS_W-1:OFS_W+1])));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        $past(xfer && armed && !base_wr && !cnt_wr && !(recycle && cur_cnt == '0))
        |-> (ofs_seen == $past(ofs_seen) + 1'b1));

    assert_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!armed && !base_wr && !cnt_wr) |-> $stable(cur_ofs));

    assert_tc_cause_R7: assert property (@(posedge clk) disable iff (rst)
        tc |-> $past(xfer && cur_cnt == '0));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
    .WORD_CHAN (WORD_CHAN),
    .PAGE_W    (PAGE_W),
    .OFS_W     (OFS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .page_wr   (page_wr),
    .base_wr   (base_wr),
    .cnt_wr    (cnt_wr),
    .xfer      (xfer),
    .recycle   (recycle),
    .phys_addr (phys_addr),
    .lane_sel  (lane_sel),
    .tc        (tc),
    .cur_ofs   (cur_ofs),
    .cur_cnt   (cur_cnt),
    .armed     (armed)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        page_wr = 1'b0;
    logic [7:0]  page_din = '0;
    logic        base_wr = 1'b0;
    logic [15:0] base_din = '0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_din = '0;
    logic        xfer = 1'b0;
    logic        recycle = 1'b0;
    logic [23:0] pa_b, pa_w;
    logic [1:0]  ln_b, ln_w;
    logic        tc_b, tc_w;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_xfer_engine #(.WORD_CHAN(1'b0)) dut (
        .clk(clk), .rst(rst), .page_wr(page_wr), .page_din(page_din),
        .base_wr(base_wr), .base_din(base_din), .cnt_wr(cnt_wr), .cnt_din(cnt_din),
        .xfer(xfer), .recycle(recycle), .phys_addr(pa_b), .lane_sel(ln_b), .tc(tc_b));

    dma_xfer_engine #(.WORD_CHAN(1'b1)) dut_w (
        .clk(clk), .rst(rst), .page_wr(page_wr), .page_din(page_din),
        .base_wr(base_wr), .base_din(base_din), .cnt_wr(cnt_wr), .cnt_din(cnt_din),
        .xfer(xfer), .recycle(recycle), .phys_addr(pa_w), .lane_sel(ln_w), .tc(tc_w));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic wr_page(input logic [7:0] v);
        page_wr = 1'b1; page_din = v; @(negedge clk); page_wr = 1'b0;
    endtask
    task automatic wr_base(input logic [15:0] v);
        base_wr = 1'b1; base_din = v; @(negedge clk); base_wr = 1'b0;
    endtask
    task automatic wr_cnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_din = v; @(negedge clk); cnt_wr = 1'b0;
    endtask
    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            xfer = 1'b1; @(negedge clk); xfer = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 byte addr after reset", pa_b, 0);
        chk("R1 word addr after reset", pa_w, 0);
        chk("R1 tc after reset", tc_b, 0);
        pulse(2);
        chk("R1 strobe ignored before programming", pa_b, 0);
    endtask

    task automatic t_mapping();
        wr_page(8'h35); wr_base(16'h1234); wr_cnt(16'd20);
        chk("R2 byte mapping", pa_b, 32'h351234);
        chk("R3 word mapping", pa_w, 32'h342468);
        chk("R11 byte lane even", ln_b, 2'b01);
        chk("R11 word lane", ln_w, 2'b11);
        wr_page(8'h34);
        chk("R3 page bit0 ignored", pa_w, 32'h342468);
        wr_page(8'h35);
    endtask

    task automatic t_step();
        pulse(3);
        chk("R4 byte step", pa_b, 32'h351237);
        chk("R4 word step", pa_w, 32'h34246E);
        chk("R11 byte lane odd", ln_b, 2'b10);
    endtask

    task automatic t_wrap();
        wr_base(16'hFFFE); wr_cnt(16'd10);
        pulse(3);
        chk("R5 byte wrap keeps page", pa_b, 32'h350001);
        chk("R5 word wrap keeps page", pa_w, 32'h340002);
    endtask

    task automatic t_stop();
        recycle = 1'b0;
        wr_page(8'h00); wr_base(16'h0100); wr_cnt(16'd2);
        pulse(2);
        chk("R6 no tc before last", tc_b, 0);
        pulse(1);
        chk("R6 tc on third transfer", tc_b, 1);
        chk("R6 word tc", tc_w, 1);
        @(negedge clk);
        chk("R7 tc single cycle", tc_b, 0);
        pulse(2);
        chk("R8 halted after tc", pa_b, 32'h000103);
        wr_cnt(16'd0);
        pulse(1);
        chk("R8 rearmed by count write", pa_b, 32'h000104);
        chk("R6 count zero one transfer", tc_b, 1);
    endtask

    task automatic t_recycle();
        recycle = 1'b1;
        wr_base(16'h0200); wr_cnt(16'd1);
        pulse(1);
        chk("R9 first step", pa_b, 32'h000201);
        pulse(1);
        chk("R9 tc with recycle", tc_b, 1);
        chk("R10 restored to written base", pa_b, 32'h000200);
        pulse(1);
        chk("R9 still accepting", pa_b, 32'h000201);
        recycle = 1'b0;
    endtask

    task automatic t_collide();
        wr_base(16'h0300); wr_cnt(16'd5);
        xfer = 1'b1; base_wr = 1'b1; base_din = 16'h0400;
        @(negedge clk);
        xfer = 1'b0; base_wr = 1'b0;
        chk("R12 write wins over strobe", pa_b, 32'h000400);
    endtask

    task automatic t_full();
        int early = 0;
        wr_base(16'h0000); wr_cnt(16'hFFFF);
        xfer = 1'b1;
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            if (tc_b) early++;
        end
        chk("R13 no tc within 65535", early, 0);
        @(negedge clk);
        xfer = 1'b0;
        chk("R13 tc on 65536th", tc_b, 1);
        chk("R13 offset wrapped", pa_b, 32'h000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_step();
        t_wrap();
        t_stop();
        t_recycle();
        t_collide();
        t_full();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule